// File: doc/BRIEF.md
# UART Host Register and Flag Controller

This block is the software-facing side of a buffered UART. A host reaches it over a 32-bit bus with byte addresses that are decoded per 32-bit word. It keeps the line configuration (word length, parity, stop bits, handshake, forced break, baud mantissa and exponent) and drives it out as plain configuration pins for the serial engines, which sit outside the block. It holds one 16-character FIFO for each direction. It keeps six sticky flags and raises one registered interrupt request from them.

Received characters arrive on a valid/ready stream. The receive engine cannot be stalled. While the receive FIFO is full, `rx_in_ready` is low, and a character offered with `rx_in_valid` during that time is lost and raises the overrun flag. Characters to transmit leave on a valid/ready stream. `tx_out_valid` stays high and `tx_out_data` stays stable until the engine takes the character with `tx_out_ready`. The host bus has no back-pressure, so a data write made while the transmit FIFO is full is dropped. The host changes flags through a write-only command word. Each flag has its own set bit and its own reset bit in that word, and the same word carries the FIFO pull and clear commands. To read a received character, software first issues a pull, which moves the FIFO head into the data register, and then reads the data register.

Top module: `uart_host_regs`

## Requirements
- R1: Word index `bus_addr[4:2]` selects the register: 0 data, 1 control (bits 25:0 read back), 2 baud (bits 15:0 read back), 3 command (write only, reads 0), 4 status (read only). Every other index reads 0, and writes to it are ignored. Reads are combinational.
- R2: The configuration pins follow the control and baud fields. Control bits: word length [8:6], parity enable 9, even parity 10, stop-bit select 11, handshake enable 12, force-break 13, receive-ready delay [21:14], transmit threshold [25:22]. Baud fields: mantissa [11:0] and exponent [15:12].
- R3: When control bit 13 is 1, `ser_txd` is 0. Otherwise `ser_txd` follows `ser_txd_raw`.
- R4: A write to the data register pushes `bus_wdata[7:0]` into the transmit FIFO. Characters leave on the transmit stream in the order they were written. A write made while 16 characters are held is ignored.
- R5: `rx_in_ready` is low while the receive FIFO holds 16 characters. A character offered while it is low is dropped and sets the overrun flag.
- R6: Command bit 10 (pull) moves the receive FIFO head into the data register, which reads back in bits [7:0]. A pull on an empty FIFO changes nothing. Command bit 11 empties the receive FIFO and bit 12 empties the transmit FIFO.
- R7: Status bits are: 0 receive-ready, 1 transmit-ready, 2 overrun, 3 break, 4 framing error, 5 parity error. Bits [10:6] hold the receive FIFO count and bits [15:11] the transmit FIFO count.
- R8: Command bits 0..4 reset receive-ready, overrun, break, framing and parity. Bits 5..9 set those same flags. When one write carries both the set bit and the reset bit of a flag, the set wins.
- R9: The `ev_break`, `ev_frame_err` and `ev_parity_err` pulses set their flags at the next edge. A hardware set wins over a software reset of the same flag in the same cycle.
- R10: Transmit-ready is set at the edge after a cycle in which the transmit count is at most the threshold. It stays set after that. Command bit 13 clears it and command bit 14 sets it. A clear has no effect while the count is at or below the threshold.
- R11: Receive-ready is set only after the receive FIFO has been non-empty for the programmed number of `bit_tick` pulses. It becomes 1 at the edge after the last counted tick. With a delay of zero, it becomes 1 at the edge after the FIFO becomes non-empty.
- R12: `irq` is registered and equals, one cycle later, the OR over the six flags, each ANDed with its enable. Enable bits in control: 0 receive-ready, 1 overrun, 2 break, 3 framing, 4 parity, 5 transmit-ready.
- R13: During reset, all registers, flags, FIFO counts and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | Write (1) or read (0) |
| bus_addr | input | 5 | Byte address, decoded by word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rx_in_valid | input | 1 | Received character offered |
| rx_in_data | input | 8 | Received character |
| rx_in_ready | output | 1 | Receive FIFO has room |
| ev_break | input | 1 | Break detected pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_parity_err | input | 1 | Parity error pulse |
| bit_tick | input | 1 | One pulse per bit time |
| tx_out_valid | output | 1 | Transmit character available |
| tx_out_data | output | 8 | Transmit FIFO head |
| tx_out_ready | input | 1 | Transmit engine takes the head |
| ser_txd_raw | input | 1 | Line level from the transmit engine |
| ser_txd | output | 1 | Line level after force-break |
| cfg_word_len | output | 3 | Word length field |
| cfg_par_en | output | 1 | Parity enable |
| cfg_par_even | output | 1 | Even parity |
| cfg_two_stop | output | 1 | Stop-bit select |
| cfg_hs_en | output | 1 | Handshake enable |
| cfg_break | output | 1 | Force-break |
| baud_mant | output | 12 | Baud mantissa |
| baud_exp | output | 4 | Baud exponent |
| irq | output | 1 | Interrupt request |

## Verification
A register write or command takes effect at the rising edge that ends the write cycle, so its result can be read back combinationally at the next falling edge. The same holds for FIFO counts, flag changes caused by commands or events, and the pulled character. Effects that go through a second register are due one edge later: `irq` follows the flags by one cycle, and transmit-ready follows a threshold change by one cycle. Receive-ready comes one edge after the last counted tick. The bench drives all inputs at falling edges and samples at the falling edge after the edge on which each result is due. For the two-stage results it checks both the earlier cycle, where the old value must remain, and the due cycle.

// File: rtl/uhr_pkg.sv
package uhr_pkg;
  // register word indices (bus_addr[4:2])
  typedef enum logic [2:0] {
    IDX_DATA = 3'd0,
    IDX_CTRL = 3'd1,
    IDX_BAUD = 3'd2,
    IDX_CMD  = 3'd3,
    IDX_STAT = 3'd4
  } reg_idx_e;

  localparam int CTRL_W = 26;
  localparam int BAUD_W = 16;
  localparam int CMD_W  = 15;
  localparam int NFLAG  = 6;
  localparam int STAT_CNT_W = 5;

  // flag vector in status order: bit0 is the LSB member (last)
  typedef struct packed {
    logic pe;
    logic fe;
    logic brk;
    logic oe;
    logic trdy;
    logic rrdy;
  } flags_t;

  // control field positions
  localparam int C_WLEN = 6;
  localparam int C_PEN  = 9;
  localparam int C_PEVN = 10;
  localparam int C_STOP = 11;
  localparam int C_HS   = 12;
  localparam int C_FBRK = 13;
  localparam int C_DLY  = 14;
  localparam int C_THR  = 22;

  // command bit positions
  localparam int K_PULL   = 10;
  localparam int K_RXCLR  = 11;
  localparam int K_TXCLR  = 12;
  localparam int K_TRDY_R = 13;
  localparam int K_TRDY_S = 14;
endpackage

// File: rtl/uhr_fifo.sv
module uhr_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push, pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready && !clear;
  assign pop       = out_valid && out_ready && !clear;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && !out_ready && !clear) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/uhr_flags.sv
module uhr_flags
  import uhr_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int DLY_W = 8,
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_over,
  input  logic             ev_brk,
  input  logic             ev_fe,
  input  logic             ev_pe,
  input  logic             bit_tick,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [NFLAG-1:0] sw_set,
  input  logic [NFLAG-1:0] sw_clr,
  input  logic [NFLAG-1:0] ie,
  input  logic [DLY_W-1:0] dly,
  input  logic [THR_W-1:0] thr,
  output flags_t           flags,
  output logic             irq
);
  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] hw_set;
  logic [DLY_W-1:0] wait_q;
  logic             rx_busy;
  logic             rrdy_cond, trdy_cond;
  logic             irq_q;

  assign rx_busy   = (rx_count != '0);
  assign rrdy_cond = rx_busy && (wait_q >= dly);
  assign trdy_cond = (tx_count <= CNT_W'(thr));

  // hardware set sources in status order
  assign hw_set = {ev_pe, ev_fe, ev_brk, ev_over, trdy_cond, rrdy_cond};

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_busy) begin
      wait_q <= '0;
    end else if (bit_tick && (wait_q < dly)) begin
      wait_q <= wait_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= hw_set[g] | sw_set[g] | (flag_q[g] & ~sw_clr[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(flag_q & ie);
  end

  assign flags = flags_t'(flag_q);
  assign irq   = irq_q;

  // R9
  brk_hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_brk |=> flags.brk);

  // R12
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ie) != '0) |=> irq);

  // R10
  trdy_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CNT_W'(thr)) |=> flags.trdy);

  // R11
  rrdy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |=> (wait_q == '0));
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uhr_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int DLY_W      = 8,
  parameter int THR_W      = 4,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_in_valid,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              rx_in_ready,
  input  logic              ev_break,
  input  logic              ev_frame_err,
  input  logic              ev_parity_err,
  input  logic              bit_tick,
  output logic              tx_out_valid,
  output logic [DATA_W-1:0] tx_out_data,
  input  logic              tx_out_ready,
  input  logic              ser_txd_raw,
  output logic              ser_txd,
  output logic [2:0]        cfg_word_len,
  output logic              cfg_par_en,
  output logic              cfg_par_even,
  output logic              cfg_two_stop,
  output logic              cfg_hs_en,
  output logic              cfg_break,
  output logic [11:0]       baud_mant,
  output logic [3:0]        baud_exp,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [BAUD_W-1:0] baud_q;
  logic [DATA_W-1:0] hold_q;
  logic [2:0]        idx;
  logic              wr;
  logic [CMD_W-1:0]  cmd;
  logic [NFLAG-1:0]  sw_set, sw_clr, ie;
  logic [CNT_W-1:0]  rx_count, tx_count;
  logic              rx_head_valid;
  logic [DATA_W-1:0] rx_head;
  logic              pull;
  logic              tx_push;
  flags_t            flags;
  logic              unused_bits;

  assign idx = bus_addr[4:2];
  assign wr  = bus_sel && bus_we;
  assign cmd = (wr && idx == IDX_CMD) ? bus_wdata[CMD_W-1:0] : '0;
  assign pull    = cmd[K_PULL];
  assign tx_push = wr && (idx == IDX_DATA);
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:CTRL_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      baud_q <= '0;
    end else if (wr) begin
      if (idx == IDX_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (idx == IDX_BAUD) baud_q <= bus_wdata[BAUD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     hold_q <= '0;
    else if (pull && rx_head_valid) hold_q <= rx_head;
  end

  // status order {pe, fe, brk, oe, trdy, rrdy}
  assign sw_clr = {cmd[4], cmd[3], cmd[2], cmd[1], cmd[K_TRDY_R], cmd[0]};
  assign sw_set = {cmd[9], cmd[8], cmd[7], cmd[6], cmd[K_TRDY_S], cmd[5]};
  assign ie     = {ctrl_q[4], ctrl_q[3], ctrl_q[2], ctrl_q[1], ctrl_q[5], ctrl_q[0]};

  uhr_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk, .rst_n,
    .clear    (cmd[K_RXCLR]),
    .in_valid (rx_in_valid),
    .in_data  (rx_in_data),
    .in_ready (rx_in_ready),
    .out_valid(rx_head_valid),
    .out_data (rx_head),
    .out_ready(pull),
    .count    (rx_count)
  );

  uhr_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk, .rst_n,
    .clear    (cmd[K_TXCLR]),
    .in_valid (tx_push),
    .in_data  (bus_wdata[DATA_W-1:0]),
    .in_ready (),
    .out_valid(tx_out_valid),
    .out_data (tx_out_data),
    .out_ready(tx_out_ready),
    .count    (tx_count)
  );

  uhr_flags #(.CNT_W(CNT_W), .DLY_W(DLY_W), .THR_W(THR_W)) u_flags (
    .clk, .rst_n,
    .ev_over (rx_in_valid && !rx_in_ready),
    .ev_brk  (ev_break),
    .ev_fe   (ev_frame_err),
    .ev_pe   (ev_parity_err),
    .bit_tick(bit_tick),
    .rx_count(rx_count),
    .tx_count(tx_count),
    .sw_set  (sw_set),
    .sw_clr  (sw_clr),
    .ie      (ie),
    .dly     (ctrl_q[C_DLY +: DLY_W]),
    .thr     (ctrl_q[C_THR +: THR_W]),
    .flags   (flags),
    .irq     (irq)
  );

  assign cfg_word_len = ctrl_q[C_WLEN +: 3];
  assign cfg_par_en   = ctrl_q[C_PEN];
  assign cfg_par_even = ctrl_q[C_PEVN];
  assign cfg_two_stop = ctrl_q[C_STOP];
  assign cfg_hs_en    = ctrl_q[C_HS];
  assign cfg_break    = ctrl_q[C_FBRK];
  assign baud_mant    = baud_q[11:0];
  assign baud_exp     = baud_q[15:12];
  assign ser_txd      = ser_txd_raw && !ctrl_q[C_FBRK];

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (idx)
        IDX_DATA: bus_rdata = 32'(hold_q);
        IDX_CTRL: bus_rdata = 32'(ctrl_q);
        IDX_BAUD: bus_rdata = 32'(baud_q);
        IDX_STAT: bus_rdata = {16'b0, STAT_CNT_W'(tx_count),
                               STAT_CNT_W'(rx_count), flags};
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R6
  pull_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pull && rx_head_valid) |=> (hold_q == $past(rx_head)));

  // R4
  tx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_count == CNT_W'(FIFO_DEPTH) && !tx_out_ready && !cmd[K_TXCLR])
      |=> (tx_count == CNT_W'(FIFO_DEPTH)));

  // R5
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && !rx_in_ready) |=> flags.oe);
endmodule

// File: tb/sim_uart_host_regs.sv
module sim_uart_host_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        rx_in_valid = 1'b0, rx_in_ready;
  logic [7:0]  rx_in_data = '0;
  logic        ev_break = 1'b0, ev_frame_err = 1'b0, ev_parity_err = 1'b0;
  logic        bit_tick = 1'b0;
  logic        tx_out_valid, tx_out_ready = 1'b0;
  logic [7:0]  tx_out_data;
  logic        ser_txd_raw = 1'b1, ser_txd;
  logic [2:0]  cfg_word_len;
  logic        cfg_par_en, cfg_par_even, cfg_two_stop, cfg_hs_en, cfg_break;
  logic [11:0] baud_mant;
  logic [3:0]  baud_exp;
  logic        irq;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_host_regs u0 (
    .clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .rx_in_valid, .rx_in_data, .rx_in_ready, .ev_break, .ev_frame_err,
    .ev_parity_err, .bit_tick, .tx_out_valid, .tx_out_data, .tx_out_ready,
    .ser_txd_raw, .ser_txd, .cfg_word_len, .cfg_par_en, .cfg_par_even,
    .cfg_two_stop, .cfg_hs_en, .cfg_break, .baud_mant, .baud_exp, .irq
  );

  // {addr, write data, expected read-back}
  localparam logic [68:0] VEC [6] = '{
    {5'd4,  32'hFFFF_FFFF, 32'h03FF_FFFF},
    {5'd4,  32'h0000_2A5C, 32'h0000_2A5C},
    {5'd8,  32'hFFFF_FFFF, 32'h0000_FFFF},
    {5'd8,  32'h0000_3ABC, 32'h0000_3ABC},
    {5'd12, 32'h0000_0000, 32'h0000_0000},
    {5'd20, 32'h0000_1234, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk);
    rx_in_valid = 1'b1; rx_in_data = d;
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    // R13 reset state
    repeat (3) @(negedge clk);
    rd(5'd16, r); check("R13 status in reset", r, 32'h0);
    rd(5'd4, r);  check("R13 control in reset", r, 32'h0);
    check("R13 irq in reset", {31'b0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 table walk
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], r);
      check("R1 readback", r, VEC[i][31:0]);
      if (i == 1) begin
        // R2 control fields, R3 force-break
        check("R2 word length", {29'b0, cfg_word_len}, 32'd1);
        check("R2 line bits", {27'b0, cfg_par_en, cfg_par_even, cfg_two_stop, cfg_hs_en, cfg_break},
              32'b10101);
        check("R3 forced break", {31'b0, ser_txd}, 32'd0);
      end
    end
    check("R2 baud fields", {16'b0, baud_exp, baud_mant}, 32'h3ABC);
    wr(5'd4, 32'h0);
    check("R3 line follows raw", {31'b0, ser_txd}, 32'd1);

    // R4 transmit path
    for (int i = 0; i < 17; i++) wr(5'd0, 32'hAB00 + 32'(8'h30 + i));
    rd(5'd16, r); check("R4 R7 tx count full", {27'b0, r[15:11]}, 32'd16);
    check("R4 head first", {24'b0, tx_out_data}, 32'h30);
    @(negedge clk); tx_out_ready = 1'b1;
    @(negedge clk); tx_out_ready = 1'b0;
    check("R4 next head", {24'b0, tx_out_data}, 32'h31);
    rd(5'd16, r); check("R4 tx count after pop", {27'b0, r[15:11]}, 32'd15);

    // R10 transmit-ready
    rd(5'd16, r); check("R10 trdy sticky", {31'b0, r[1]}, 32'd1);
    wr(5'd12, 32'h2000);
    rd(5'd16, r); check("R10 trdy cleared", {31'b0, r[1]}, 32'd0);
    wr(5'd4, 32'h03C0_0000);
    rd(5'd16, r); check("R10 trdy lags threshold", {31'b0, r[1]}, 32'd0);
    @(negedge clk);
    rd(5'd16, r); check("R10 trdy under threshold", {31'b0, r[1]}, 32'd1);
    wr(5'd12, 32'h2000);
    rd(5'd16, r); check("R10 clear ignored at threshold", {31'b0, r[1]}, 32'd1);
    wr(5'd12, 32'h1000);
    rd(5'd16, r); check("R6 tx clear", {27'b0, r[15:11]}, 32'd0);
    check("R6 tx stream idle", {31'b0, tx_out_valid}, 32'd0);
    wr(5'd4, 32'h0);

    // R11 receive-ready delay
    wr(5'd12, 32'h1F);
    wr(5'd4, 32'h0000_C000);
    rx_push(8'h5A);
    repeat (3) @(negedge clk);
    rd(5'd16, r); check("R11 rrdy before ticks", {31'b0, r[0]}, 32'd0);
    tick_once(); tick_once();
    rd(5'd16, r); check("R11 rrdy after two ticks", {31'b0, r[0]}, 32'd0);
    tick_once();
    rd(5'd16, r); check("R11 rrdy at third tick edge", {31'b0, r[0]}, 32'd0);
    @(negedge clk);
    rd(5'd16, r); check("R11 rrdy set", {31'b0, r[0]}, 32'd1);
    check("R7 rx count", {27'b0, r[10:6]}, 32'd1);

    // R6 pull
    wr(5'd12, 32'h400);
    rd(5'd0, r);  check("R6 pulled char", r, 32'h5A);
    rd(5'd16, r); check("R6 rx count after pull", {27'b0, r[10:6]}, 32'd0);
    wr(5'd12, 32'h1);
    rd(5'd16, r); check("R8 rrdy reset", {31'b0, r[0]}, 32'd0);
    wr(5'd12, 32'h400);
    rd(5'd0, r);  check("R6 pull on empty", r, 32'h5A);

    // R11 zero delay
    wr(5'd4, 32'h0);
    rx_push(8'h11);
    rd(5'd16, r); check("R11 zero delay lag", {31'b0, r[0]}, 32'd0);
    @(negedge clk);
    rd(5'd16, r); check("R11 zero delay set", {31'b0, r[0]}, 32'd1);
    wr(5'd12, 32'h800);
    rd(5'd16, r); check("R6 rx clear", {27'b0, r[10:6]}, 32'd0);
    wr(5'd12, 32'h1F);

    // R5 overrun
    for (int i = 0; i < 16; i++) rx_push(8'(8'h40 + i));
    check("R5 ready low when full", {31'b0, rx_in_ready}, 32'd0);
    rd(5'd16, r); check("R5 no overrun yet", {31'b0, r[2]}, 32'd0);
    rx_push(8'hEE);
    rd(5'd16, r); check("R5 overrun set", {31'b0, r[2]}, 32'd1);
    check("R5 count stays full", {27'b0, r[10:6]}, 32'd16);
    wr(5'd12, 32'h400);
    rd(5'd0, r); check("R5 oldest kept", r, 32'h40);
    wr(5'd12, 32'h802);

    // R8 set and reset via command word
    wr(5'd12, 32'h3E0);
    rd(5'd16, r); check("R8 set all", {26'b0, r[5:0]}, 32'h3F);
    wr(5'd12, 32'h1F);
    rd(5'd16, r); check("R8 reset all", {26'b0, r[5:0]}, 32'h02);
    wr(5'd12, 32'h84);
    rd(5'd16, r); check("R8 set wins", {31'b0, r[3]}, 32'd1);
    wr(5'd12, 32'h4);

    // R9 hardware events
    @(negedge clk);
    ev_break = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'd12; bus_wdata = 32'h4;
    @(negedge clk);
    ev_break = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    rd(5'd16, r); check("R9 hw beats sw reset", {31'b0, r[3]}, 32'd1);
    @(negedge clk); ev_frame_err = 1'b1; ev_parity_err = 1'b1;
    @(negedge clk); ev_frame_err = 1'b0; ev_parity_err = 1'b0;
    rd(5'd16, r); check("R9 framing and parity", {30'b0, r[5:4]}, 32'd3);

    // R12 interrupt
    wr(5'd12, 32'h1F);
    wr(5'd4, 32'h4);
    @(negedge clk);
    check("R12 irq idle", {31'b0, irq}, 32'd0);
    wr(5'd12, 32'h80);
    check("R12 irq lags flag", {31'b0, irq}, 32'd0);
    @(negedge clk);
    check("R12 irq raised", {31'b0, irq}, 32'd1);
    wr(5'd12, 32'h4);
    check("R12 irq one cycle late", {31'b0, irq}, 32'd1);
    @(negedge clk);
    check("R12 irq dropped", {31'b0, irq}, 32'd0);
    wr(5'd4, 32'h20);
    @(negedge clk);
    check("R12 trdy enable", {31'b0, irq}, 32'd1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule